// File: doc/BRIEF.md
# Memory Command Dispatcher with CSR Slot

This block sits behind a command inlet queue of a memory channel and sends each command at the queue head to where it is carried out. Memory reads, and transmit-buffer writes (which are served by reading memory), go to one of four per-bank command queues. The bank is chosen by a two-bit field of the command address. Reads and writes of the channel's control/status registers (CSRs) are held in one CSR slot. The slot stays occupied until the access is complete.

A CSR write issues its pull identifier to a pull arbiter through a valid/ready handshake. When the identifier is accepted, a tag naming the target CSR is placed in a small in-order pull-in-progress queue. Returning pull data pops that tag, is stored into the named CSR and frees the slot. A CSR read offers the register's contents to the push path with a valid/ready handshake and frees the slot once the data is taken. Blocking is decided per destination. A full bank queue holds a memory command at the inlet head. An occupied CSR slot holds only CSR commands, and memory commands keep flowing while it is busy.

Top module: `mem_cmd_dispatch`

## Requirements
- R1: A command with kind 2'b00 (memory read) or 2'b01 (transmit-buffer write) is taken from the inlet head in the same cycle it is presented, provided the bank it addresses is not full. The bank is in_addr[BANK_LSB+1:BANK_LSB]. In that cycle bank_push is one-hot on that bank, and bank_cmd_tbuf equals kind bit 0. bank_cmd_addr and bank_cmd_id repeat the command's address and identifier.
- R2: When the addressed bank's full flag is set, a memory command is not taken and no bank push occurs. A memory command is still taken while the CSR slot is occupied.
- R3: A command with kind 2'b10 (CSR read) or 2'b11 (CSR write) is taken only while the CSR slot is empty. At most one command is taken per clock.
- R4: From the cycle after a CSR write is taken, pull_req_valid is high and pull_req_id holds the command's identifier. Both are held until pull_req_ready is seen, and pull_req_valid falls in the cycle after that handshake.
- R5: Each accepted pull identifier records the target CSR index, in_addr[CSR_W-1:0], as a tag in a pull-in-progress queue of 2^PIP_AW entries. Pull data that arrives while no tag is outstanding changes no CSR.
- R6: Pull data that arrives while a tag is outstanding pops the oldest tag and is written into the CSR it names. The CSR slot is then empty from the next cycle.
- R7: From the cycle after a CSR read is taken, push_valid is high. push_data holds the addressed CSR and push_id holds the command's identifier. These are held until push_ready is seen, and the slot is empty in the cycle after that handshake.
- R8: After reset every CSR reads zero, the CSR slot is empty, and pull_req_valid, push_valid and bank_push are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A command is at the inlet head |
| in_kind | input | 2 | Command kind: 00 memory read, 01 transmit-buffer write, 10 CSR read, 11 CSR write |
| in_addr | input | ADDR_W | Command address |
| in_id | input | ID_W | Push or pull identifier of the command |
| in_pop | output | 1 | Inlet head is taken this cycle |
| bank_full | input | 4 | Full flag of each bank command queue |
| bank_push | output | 4 | One-hot write strobe into a bank command queue |
| bank_cmd_tbuf | output | 1 | Command written to a bank is a transmit-buffer write |
| bank_cmd_addr | output | ADDR_W | Address written to the bank queue |
| bank_cmd_id | output | ID_W | Identifier written to the bank queue |
| pull_req_valid | output | 1 | Pull identifier offered to the pull arbiter |
| pull_req_id | output | ID_W | Pull identifier |
| pull_req_ready | input | 1 | Pull arbiter accepts the identifier |
| pull_data_valid | input | 1 | Pull data returns this cycle |
| pull_data | input | DATA_W | Returned pull data |
| push_valid | output | 1 | CSR read data offered to the push path |
| push_data | output | DATA_W | CSR read data |
| push_id | output | ID_W | Push identifier of the CSR read |
| push_ready | input | 1 | Push path takes the data |

## Verification
The bench builds the block with its defaults. The bank field sits at bit 6 and there are eight 32-bit CSRs. This keeps every bank and every CSR index within reach of short random addresses, so each bank's full flag and each register's write-then-read round trip are exercised many times. Random stall lengths on both handshakes test that the outputs are held. A mixed memory command sent during every CSR write checks that blocking is per destination. Stray pull data with no tag outstanding is followed by a read of all CSRs.

// File: rtl/mem_cmd_dispatch.sv
module mem_cmd_dispatch #(
  parameter int ADDR_W   = 32,
  parameter int ID_W     = 8,
  parameter int DATA_W   = 32,
  parameter int BANK_W   = 2,
  parameter int BANK_LSB = 6,
  parameter int CSR_W    = 3,
  parameter int PIP_AW   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [1:0]             in_kind,
  input  logic [ADDR_W-1:0]      in_addr,
  input  logic [ID_W-1:0]        in_id,
  output logic                   in_pop,
  input  logic [(1<<BANK_W)-1:0] bank_full,
  output logic [(1<<BANK_W)-1:0] bank_push,
  output logic                   bank_cmd_tbuf,
  output logic [ADDR_W-1:0]      bank_cmd_addr,
  output logic [ID_W-1:0]        bank_cmd_id,
  output logic                   pull_req_valid,
  output logic [ID_W-1:0]        pull_req_id,
  input  logic                   pull_req_ready,
  input  logic                   pull_data_valid,
  input  logic [DATA_W-1:0]      pull_data,
  output logic                   push_valid,
  output logic [DATA_W-1:0]      push_data,
  output logic [ID_W-1:0]        push_id,
  input  logic                   push_ready
);
  localparam int NBANK = 1 << BANK_W;
  localparam int NCSR  = 1 << CSR_W;
  localparam int DEPTH = 1 << PIP_AW;

  logic              slot_busy, slot_wr, slot_sent;
  logic [CSR_W-1:0]  slot_idx;
  logic [ID_W-1:0]   slot_id;
  logic [DATA_W-1:0] csr_q [NCSR];
  logic [CSR_W-1:0]  pip_tag [DEPTH];
  logic [PIP_AW-1:0] pip_wp, pip_rp;
  logic [PIP_AW:0]   pip_cnt;

  wire              is_mem   = ~in_kind[1];
  wire [BANK_W-1:0] bank_sel = in_addr[BANK_LSB +: BANK_W];
  wire [NBANK-1:0]  bank_hot = NBANK'(1) << bank_sel;

  assign in_pop        = in_valid & (is_mem ? ~bank_full[bank_sel] : ~slot_busy);
  assign bank_push     = (in_pop & is_mem) ? bank_hot : '0;
  assign bank_cmd_tbuf = in_kind[0];
  assign bank_cmd_addr = in_addr;
  assign bank_cmd_id   = in_id;

  wire csr_take  = in_pop & ~is_mem;
  assign pull_req_valid = slot_busy & slot_wr & ~slot_sent;
  assign pull_req_id    = slot_id;
  wire pull_fire = pull_req_valid & pull_req_ready;
  wire pip_pop   = pull_data_valid & (pip_cnt != '0);

  assign push_valid = slot_busy & ~slot_wr;
  assign push_data  = csr_q[slot_idx];
  assign push_id    = slot_id;
  wire push_fire = push_valid & push_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_busy <= 1'b0;
      slot_wr   <= 1'b0;
      slot_sent <= 1'b0;
      slot_idx  <= '0;
      slot_id   <= '0;
    end else begin
      if (csr_take) begin
        slot_busy <= 1'b1;
        slot_wr   <= in_kind[0];
        slot_sent <= 1'b0;
        slot_idx  <= in_addr[CSR_W-1:0];
        slot_id   <= in_id;
      end else if (push_fire || pip_pop) begin
        slot_busy <= 1'b0;
      end
      if (pull_fire) slot_sent <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pip_wp  <= '0;
      pip_rp  <= '0;
      pip_cnt <= '0;
    end else begin
      if (pull_fire) begin
        pip_tag[pip_wp] <= slot_idx;
        pip_wp <= pip_wp + 1'b1;
      end
      if (pip_pop) pip_rp <= pip_rp + 1'b1;
      case ({pull_fire, pip_pop})
        2'b10:   pip_cnt <= pip_cnt + 1'b1;
        2'b01:   pip_cnt <= pip_cnt - 1'b1;
        default: pip_cnt <= pip_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCSR; i++) csr_q[i] <= '0;
    end else if (pip_pop) begin
      csr_q[pip_tag[pip_rp]] <= pull_data;
    end
  end

  p_bank_hol_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_mem && bank_full[bank_sel]) |-> (!in_pop && bank_push == '0));
  p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_push));
  p_csr_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_mem && slot_busy) |-> !in_pop);
  p_pull_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_req_valid && !pull_req_ready) |=> (pull_req_valid && $stable(pull_req_id)));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pull_fire |-> !pip_cnt[PIP_AW]);
  p_slot_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pip_pop |=> !slot_busy);
  p_push_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_data) && $stable(push_id)));
  p_push_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> !push_valid);
endmodule

// File: tb/tb_mem_cmd_dispatch.sv
module tb_mem_cmd_dispatch;
  localparam int ADDR_W = 32, ID_W = 8, DATA_W = 32, BANK_LSB = 6, NCSR = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0; logic [1:0] in_kind = 0;
  logic [ADDR_W-1:0] in_addr = 0; logic [ID_W-1:0] in_id = 0;
  logic in_pop; logic [3:0] bank_full = 0, bank_push;
  logic bank_cmd_tbuf; logic [ADDR_W-1:0] bank_cmd_addr; logic [ID_W-1:0] bank_cmd_id;
  logic pull_req_valid; logic [ID_W-1:0] pull_req_id; logic pull_req_ready = 0;
  logic pull_data_valid = 0; logic [DATA_W-1:0] pull_data = 0;
  logic push_valid; logic [DATA_W-1:0] push_data; logic [ID_W-1:0] push_id;
  logic push_ready = 0;

  int checks = 0, errors = 0;
  logic [DATA_W-1:0] exp_csr [NCSR];

  always #5 clk = ~clk;

  mem_cmd_dispatch dut (.*);

  function automatic logic [3:0] exp_hot(logic [ADDR_W-1:0] a);
    return 4'b0001 << a[BANK_LSB +: 2];
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic mem_op(logic [1:0] kind, logic [ADDR_W-1:0] a, logic [3:0] full);
    logic [ID_W-1:0] id = ID_W'($urandom);
    logic take;
    @(negedge clk);
    in_valid = 1; in_kind = kind; in_addr = a; in_id = id; bank_full = full;
    take = !(|(full & exp_hot(a)));
    #1;
    if (take) begin
      chk(in_pop == 1, "R1", "in_pop", in_pop, 1);
      chk(bank_push == exp_hot(a), "R1", "bank_push", bank_push, exp_hot(a));
      chk(bank_cmd_tbuf == kind[0] && bank_cmd_addr == a && bank_cmd_id == id,
          "R1", "bank_cmd", {bank_cmd_tbuf, bank_cmd_id, bank_cmd_addr}, {kind[0], id, a});
    end else begin
      chk(in_pop == 0, "R2", "in_pop blocked", in_pop, 0);
      chk(bank_push == 0, "R2", "bank_push blocked", bank_push, 0);
    end
    @(posedge clk); @(negedge clk);
    in_valid = 0; bank_full = 0;
  endtask

  task automatic csr_write(int idx, logic [DATA_W-1:0] val, int stall);
    logic [ID_W-1:0] id = ID_W'($urandom);
    logic [ADDR_W-1:0] ma = ADDR_W'($urandom);
    @(negedge clk);
    in_valid = 1; in_kind = 2'b11; in_addr = ADDR_W'(idx) | (ADDR_W'($urandom) << 3); in_id = id;
    #1 chk(in_pop == 1, "R3", "csr write taken", in_pop, 1);
    @(posedge clk); @(negedge clk);
    in_kind = 2'b00; in_addr = ma; bank_full = 4'b0000;
    #1 chk(in_pop == 1 && bank_push == exp_hot(ma), "R2", "mem passes busy slot", bank_push, exp_hot(ma));
    chk(pull_req_valid == 1 && pull_req_id == id, "R4", "pull request", {pull_req_valid, pull_req_id}, {1'b1, id});
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    for (int s = 0; s < stall; s++) begin
      #1 chk(pull_req_valid == 1 && pull_req_id == id, "R4", "pull held", pull_req_id, id);
      @(posedge clk); @(negedge clk);
    end
    pull_req_ready = 1;
    #1 chk(pull_req_valid == 1, "R4", "pull valid at handshake", pull_req_valid, 1);
    @(posedge clk); @(negedge clk);
    pull_req_ready = 0;
    in_valid = 1; in_kind = 2'b10; in_addr = ADDR_W'($urandom);
    #1 chk(pull_req_valid == 0, "R4", "pull drops after handshake", pull_req_valid, 0);
    chk(in_pop == 0, "R3", "csr blocked while slot busy", in_pop, 0);
    pull_data_valid = 1; pull_data = val;
    @(posedge clk); @(negedge clk);
    pull_data_valid = 0; in_valid = 0;
    exp_csr[idx] = val;
  endtask

  task automatic csr_read(int idx, int stall, string req);
    logic [ID_W-1:0] id = ID_W'($urandom);
    @(negedge clk);
    in_valid = 1; in_kind = 2'b10; in_addr = ADDR_W'(idx) | (ADDR_W'($urandom) << 3); in_id = id;
    #1 chk(in_pop == 1, "R6", "slot free for next csr", in_pop, 1);
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    for (int s = 0; s < stall; s++) begin
      #1 chk(push_valid == 1 && push_id == id, "R7", "push held", push_id, id);
      @(posedge clk); @(negedge clk);
    end
    push_ready = 1;
    #1 chk(push_valid == 1 && push_id == id, "R7", "push valid/id", {push_valid, push_id}, {1'b1, id});
    chk(push_data == exp_csr[idx], req, $sformatf("csr%0d data", idx), push_data, exp_csr[idx]);
    @(posedge clk); @(negedge clk);
    push_ready = 0;
    #1 chk(push_valid == 0, "R7", "push drops after handshake", push_valid, 0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4051));
    for (int i = 0; i < NCSR; i++) exp_csr[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk(pull_req_valid == 0 && push_valid == 0 && bank_push == 0 && in_pop == 0,
        "R8", "idle outputs", {pull_req_valid, push_valid, bank_push}, 0);
    for (int i = 0; i < NCSR; i++) csr_read(i, 0, "R8");

    // directed: every bank, both memory kinds, full and not full
    for (int b = 0; b < 4; b++) begin
      mem_op(2'b00, ADDR_W'(b) << BANK_LSB, 4'b0000);
      mem_op(2'b01, ADDR_W'(b) << BANK_LSB, ~(4'b0001 << b));
      mem_op(2'b00, ADDR_W'(b) << BANK_LSB, 4'b0001 << b);
    end

    // directed: stray pull data with no tag outstanding (R5)
    @(negedge clk); pull_data_valid = 1; pull_data = 32'hDEAD_BEEF;
    @(posedge clk); @(negedge clk); pull_data_valid = 0;
    for (int i = 0; i < NCSR; i++) csr_read(i, 0, "R5");

    // directed: write/read extreme indices and values
    csr_write(0, 32'hFFFF_FFFF, 0);
    csr_write(NCSR - 1, 32'h0000_0001, 3);
    csr_read(0, 2, "R6");
    csr_read(NCSR - 1, 0, "R6");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 2);
      if (op == 0)
        mem_op(2'($urandom_range(0, 1)), ADDR_W'($urandom), 4'($urandom));
      else if (op == 1)
        csr_write($urandom_range(0, NCSR - 1), DATA_W'($urandom), $urandom_range(0, 3));
      else
        csr_read($urandom_range(0, NCSR - 1), $urandom_range(0, 3), "R6");
    end

    for (int i = 0; i < NCSR; i++) csr_read(i, 1, "R6");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule